// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block steers a small set of local interrupt sources onto the IRQ and FIQ lines of four processor cores, and shows each core a pending word that lists the sources currently reaching it. Each core has four timer request lines, a four-bit mailbox summary, and a PMU request line. One GPU request is shared by all cores. An AXI-outstanding request and a local-timer request are also shared. The timers, the PMU logic and the mailbox storage sit outside the block; only their request lines enter it.

Software programs the routing through a 32-bit register bus. Each core has a timer configuration register. The single GPU request goes to exactly one core, picked by two-bit core-select fields. PMU enables change only through a write-set address and a write-clear address. There is also a control word and a prescaler word, both plain storage. The IRQ and FIQ outputs are combinational in the routing registers and the request inputs.

Bus accesses pass through a two-state machine. In `ST_IDLE`, a request is accepted: a write takes effect, or read data is captured, at that clock edge. The transition IDLE-to-ACK follows. In `ST_ACK`, `bus_ack` is high for one cycle with the read data, and the ACK-to-IDLE transition always follows. A request still held during `ST_ACK` is not taken again.

Top module: `lirq_router`

## Requirements
- R1: After reset, every register reads zero and no IRQ or FIQ is raised while no request is asserted. Because the GPU route resets to zero, a GPU request then raises IRQ of core 0 only.
- R2: A request seen in the idle state is accepted at that clock edge. `bus_ack` is high in the following cycle, for one cycle only, with `bus_rdata` valid. Reads of unmapped byte offsets return zero.
- R3: The control word at offset 0x00 and the prescaler word at offset 0x08 store and return all 32 bits.
- R4: The timer configuration of core n is at 0x40+4n and holds eight bits. Bit t (0..3) routes timer t of core n to IRQ, and bit t+4 routes it to FIQ. Upper bits read zero. Writing zero stops all timer routing for that core.
- R5: The pending word of core n is at 0x60+4n, in bits 11:0. Bits 3:0 are timers 0..3, bits 7:4 are mailboxes 0..3, bit 8 is GPU, bit 9 is PMU, bit 10 is AXI and bit 11 is the local timer. A bit reads 1 only while its source is asserted and routed to core n.
- R6: The GPU route is at 0x0C and holds five bits. Bits 1:0 name the IRQ core, bits 3:2 name the FIQ core, and bit 4 selects FIQ delivery (1) over IRQ delivery (0). The GPU request reaches exactly one core.
- R7: A write to 0x10 sets, and a write to 0x14 clears, the PMU enables whose data bits are 1. Bit n is the IRQ enable of core n and bit n+4 is its FIQ enable. A read of either address returns the current enables in that layout.
- R8: Mailbox requests of core n always route to the IRQ of core n. The AXI and local-timer requests route to the IRQ of core 0 only.
- R9: The IRQ of each core is the OR of its IRQ-routed sources, and its FIQ is the OR of its FIQ-routed sources.
- R10: Pending words are read-only; writes to 0x60..0x6C change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access done |
| timer_req | input | 16 | Timer requests, bits 4n+3:4n belong to core n |
| mbox_req | input | 16 | Mailbox summaries, bits 4n+3:4n belong to core n |
| gpu_req | input | 1 | Shared GPU request |
| pmu_req | input | 4 | PMU request per core |
| axi_req | input | 1 | AXI-outstanding request |
| ltmr_req | input | 1 | Local timer request |
| irq | output | 4 | IRQ per core |
| fiq | output | 4 | FIQ per core |

## Verification
A wrong routing bit shows up on `irq` or `fiq` in the same cycle, because the outputs are combinational. The sweeps drive every timer pattern against every configuration value of each core, and every GPU route value against every core. A corrupted register is therefore seen at the next comparison, which comes at most one bus access later. A fault in the access state machine shows as a missing or doubled `bus_ack`, or as stale read data, on the very next transfer.

// File: rtl/lirq_pkg.sv
`timescale 1ns/1ps
package lirq_pkg;
    localparam int unsigned SRC_N  = 12;  // pending bits per core
    localparam int unsigned TMR_N  = 4;   // timers per core
    localparam int unsigned TCFG_W = 2 * TMR_N;
    localparam int unsigned GRT_W  = 5;   // gpu route width
    localparam int unsigned GSEL_W = 2;   // core-select field width

    localparam int unsigned BIT_GPU  = 8;
    localparam int unsigned BIT_PMU  = 9;
    localparam int unsigned BIT_AXI  = 10;
    localparam int unsigned BIT_LTMR = 11;

    localparam logic [7:0] OFS_CTRL    = 8'h00;
    localparam logic [7:0] OFS_PRESC   = 8'h08;
    localparam logic [7:0] OFS_GPU     = 8'h0C;
    localparam logic [7:0] OFS_PMU_SET = 8'h10;
    localparam logic [7:0] OFS_PMU_CLR = 8'h14;
    localparam logic [7:0] OFS_TCFG    = 8'h40;
    localparam logic [7:0] OFS_PEND    = 8'h60;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_state_e;
endpackage

// File: rtl/lirq_regs.sv
`timescale 1ns/1ps
module lirq_regs
    import lirq_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [AW-1:0]             bus_addr,
    input  logic [DW-1:0]             bus_wdata,
    output logic [DW-1:0]             bus_rdata,
    output logic                      bus_ack,
    input  logic [NCORE*SRC_N-1:0]    pend_flat,
    output logic [NCORE*TCFG_W-1:0]   tcfg_flat,
    output logic [GRT_W-1:0]          gpu_route,
    output logic [NCORE-1:0]          pmu_irq_en,
    output logic [NCORE-1:0]          pmu_fiq_en
);
    localparam int IDXW = (NCORE > 1) ? $clog2(NCORE) : 1;
    localparam logic [AW-1:0] WIN = AW'(4 * NCORE);

    bus_state_e st_q, st_d;
    logic [DW-1:0]     ctrl_q, presc_q, rdata_q, rd_d;
    logic [TCFG_W-1:0] tcfg_q [NCORE];
    logic [GRT_W-1:0]  gpu_q;
    logic [NCORE-1:0]  pirq_q, pfiq_q;

    logic          access, wr;
    logic [AW-1:0] ofs_t, ofs_p;
    logic          hit_t, hit_p;
    logic [IDXW-1:0] idx_t, idx_p;

    assign access = (st_q == ST_IDLE) && bus_req;
    assign wr     = access && bus_we;
    assign ofs_t  = bus_addr - AW'(OFS_TCFG);
    assign ofs_p  = bus_addr - AW'(OFS_PEND);
    assign hit_t  = (bus_addr[1:0] == 2'b00) && (ofs_t < WIN);
    assign hit_p  = (bus_addr[1:0] == 2'b00) && (ofs_p < WIN);
    assign idx_t  = ofs_t[2 +: IDXW];
    assign idx_p  = ofs_p[2 +: IDXW];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (bus_req) st_d = ST_ACK;
            ST_ACK:  st_d = ST_IDLE;
        endcase
    end

    // read mux
    always_comb begin
        rd_d = '0;
        if (bus_addr == AW'(OFS_CTRL))         rd_d = ctrl_q;
        else if (bus_addr == AW'(OFS_PRESC))   rd_d = presc_q;
        else if (bus_addr == AW'(OFS_GPU))     rd_d = DW'(gpu_q);
        else if (bus_addr == AW'(OFS_PMU_SET) || bus_addr == AW'(OFS_PMU_CLR))
            rd_d = DW'({pfiq_q, {(4-NCORE){1'b0}}, pirq_q}) ;
        else if (hit_t)                        rd_d = DW'(tcfg_q[idx_t]);
        else if (hit_p)                        rd_d = DW'(pend_flat[idx_p*SRC_N +: SRC_N]);
    end

    // register writes and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            gpu_q   <= '0;
            pirq_q  <= '0;
            pfiq_q  <= '0;
            rdata_q <= '0;
            for (int n = 0; n < NCORE; n++) tcfg_q[n] <= '0;
        end else begin
            if (access) rdata_q <= rd_d;
            if (wr) begin
                if (bus_addr == AW'(OFS_CTRL))  ctrl_q  <= bus_wdata;
                if (bus_addr == AW'(OFS_PRESC)) presc_q <= bus_wdata;
                if (bus_addr == AW'(OFS_GPU))   gpu_q   <= bus_wdata[GRT_W-1:0];
                if (bus_addr == AW'(OFS_PMU_SET)) begin
                    pirq_q <= pirq_q | bus_wdata[NCORE-1:0];
                    pfiq_q <= pfiq_q | bus_wdata[4 +: NCORE];
                end
                if (bus_addr == AW'(OFS_PMU_CLR)) begin
                    pirq_q <= pirq_q & ~bus_wdata[NCORE-1:0];
                    pfiq_q <= pfiq_q & ~bus_wdata[4 +: NCORE];
                end
                if (hit_t) tcfg_q[idx_t] <= bus_wdata[TCFG_W-1:0];
            end
        end
    end

    // outputs
    assign bus_ack    = (st_q == ST_ACK);
    assign bus_rdata  = rdata_q;
    assign gpu_route  = gpu_q;
    assign pmu_irq_en = pirq_q;
    assign pmu_fiq_en = pfiq_q;
    for (genvar n = 0; n < NCORE; n++) begin : g_tcfg
        assign tcfg_flat[n*TCFG_W +: TCFG_W] = tcfg_q[n];
    end

    // R2: acknowledge lasts one cycle and follows every accepted request
    a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> bus_ack);
    // R7: set and clear addresses act on the named bits
    a_r7_pmu_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == AW'(OFS_PMU_SET)) |=>
        (((pmu_irq_en & $past(bus_wdata[NCORE-1:0])) == $past(bus_wdata[NCORE-1:0])) &&
         ((pmu_fiq_en & $past(bus_wdata[4 +: NCORE])) == $past(bus_wdata[4 +: NCORE]))));
    a_r7_pmu_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == AW'(OFS_PMU_CLR)) |=>
        (((pmu_irq_en & $past(bus_wdata[NCORE-1:0])) == '0) &&
         ((pmu_fiq_en & $past(bus_wdata[4 +: NCORE])) == '0)));
    // R10: a write to a pending word leaves all routing state alone
    a_r10_pend_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_p) |=> ($stable(tcfg_flat) && $stable(gpu_route) &&
                           $stable(pmu_irq_en) && $stable(pmu_fiq_en)));
endmodule

// File: rtl/lirq_core.sv
`timescale 1ns/1ps
module lirq_core
    import lirq_pkg::*;
#(
    parameter int CORE_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_N-1:0]  tmr_req,
    input  logic [3:0]        mbx_req,
    input  logic              gpu_req,
    input  logic              pmu_req,
    input  logic              axi_req,
    input  logic              ltmr_req,
    input  logic [TCFG_W-1:0] tcfg,
    input  logic [GRT_W-1:0]  gpu_route,
    input  logic              pmu_irq_en,
    input  logic              pmu_fiq_en,
    output logic [SRC_N-1:0]  pend,
    output logic              irq,
    output logic              fiq,
    output logic              gpu_hit
);
    localparam logic [GSEL_W-1:0] MY_ID = GSEL_W'(CORE_ID);
    localparam logic              HOME  = (CORE_ID == 0);

    logic [TMR_N-1:0] t_irq, t_fiq;
    logic gpu_irq, gpu_fiq, axi_here, ltmr_here;

    assign t_irq     = tmr_req & tcfg[TMR_N-1:0];
    assign t_fiq     = tmr_req & tcfg[TCFG_W-1:TMR_N];
    assign gpu_irq   = gpu_req && !gpu_route[4] && (gpu_route[1:0] == MY_ID);
    assign gpu_fiq   = gpu_req &&  gpu_route[4] && (gpu_route[3:2] == MY_ID);
    assign gpu_hit   = gpu_irq || gpu_fiq;
    assign axi_here  = HOME && axi_req;
    assign ltmr_here = HOME && ltmr_req;

    always_comb begin
        pend              = '0;
        pend[TMR_N-1:0]   = t_irq | t_fiq;
        pend[7:4]         = mbx_req;
        pend[BIT_GPU]     = gpu_hit;
        pend[BIT_PMU]     = pmu_req && (pmu_irq_en || pmu_fiq_en);
        pend[BIT_AXI]     = axi_here;
        pend[BIT_LTMR]    = ltmr_here;
    end

    assign irq = (|t_irq) || (|mbx_req) || gpu_irq || (pmu_req && pmu_irq_en)
                 || axi_here || ltmr_here;
    assign fiq = (|t_fiq) || gpu_fiq || (pmu_req && pmu_fiq_en);

    // R9: no interrupt line without a pending source behind it
    a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0));
    a_r9_fiq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        fiq |-> (pend != '0));
    // R8: a mailbox request always reaches this core's IRQ
    a_r8_mbox_to_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mbx_req != '0) |-> irq);
    // R4: an all-zero timer configuration blocks every timer of the core
    a_r4_zero_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (tcfg == '0) |-> (pend[TMR_N-1:0] == '0));
endmodule

// File: rtl/lirq_router.sv
`timescale 1ns/1ps
module lirq_router
    import lirq_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_req,
    input  logic                   bus_we,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    output logic                   bus_ack,
    input  logic [NCORE*TMR_N-1:0] timer_req,
    input  logic [NCORE*4-1:0]     mbox_req,
    input  logic                   gpu_req,
    input  logic [NCORE-1:0]       pmu_req,
    input  logic                   axi_req,
    input  logic                   ltmr_req,
    output logic [NCORE-1:0]       irq,
    output logic [NCORE-1:0]       fiq
);
    logic [NCORE*SRC_N-1:0]  pend_flat;
    logic [NCORE*TCFG_W-1:0] tcfg_flat;
    logic [GRT_W-1:0]        gpu_route;
    logic [NCORE-1:0]        pmu_irq_en, pmu_fiq_en, gpu_hit;

    lirq_regs #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ack    (bus_ack),
        .pend_flat  (pend_flat),
        .tcfg_flat  (tcfg_flat),
        .gpu_route  (gpu_route),
        .pmu_irq_en (pmu_irq_en),
        .pmu_fiq_en (pmu_fiq_en)
    );

    for (genvar n = 0; n < NCORE; n++) begin : g_core
        lirq_core #(.CORE_ID(n)) u_core (
            .clk        (clk),
            .rst_n      (rst_n),
            .tmr_req    (timer_req[n*TMR_N +: TMR_N]),
            .mbx_req    (mbox_req[n*4 +: 4]),
            .gpu_req    (gpu_req),
            .pmu_req    (pmu_req[n]),
            .axi_req    (axi_req),
            .ltmr_req   (ltmr_req),
            .tcfg       (tcfg_flat[n*TCFG_W +: TCFG_W]),
            .gpu_route  (gpu_route),
            .pmu_irq_en (pmu_irq_en[n]),
            .pmu_fiq_en (pmu_fiq_en[n]),
            .pend       (pend_flat[n*SRC_N +: SRC_N]),
            .irq        (irq[n]),
            .fiq        (fiq[n]),
            .gpu_hit    (gpu_hit[n])
        );
    end

    // R6: the shared GPU request lands on exactly one core
    a_r6_gpu_one_core: assert property (@(posedge clk) disable iff (!rst_n)
        gpu_req |-> ($countones(gpu_hit) == 1));
    a_r6_gpu_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !gpu_req |-> (gpu_hit == '0));
endmodule

// File: tb/lirq_router_bench.sv
`timescale 1ns/1ps
module lirq_router_bench;
    localparam int NC = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [15:0] timer_req = '0, mbox_req = '0;
    logic        gpu_req = 1'b0, axi_req = 1'b0, ltmr_req = 1'b0;
    logic [3:0]  pmu_req = '0;
    logic [3:0]  irq, fiq;

    lirq_router u_lirq_router (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .timer_req(timer_req), .mbox_req(mbox_req),
        .gpu_req(gpu_req), .pmu_req(pmu_req), .axi_req(axi_req),
        .ltmr_req(ltmr_req), .irq(irq), .fiq(fiq)
    );

    int n_cmp = 0, n_bad = 0;
    logic [7:0] m_tcfg [NC];
    logic [4:0] m_gpu = '0;
    logic [3:0] m_pi = '0, m_pf = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        chk("R2 ack", {31'b0, bus_ack}, 32'd1);
        r = bus_rdata;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        if (a == 8'h0C) m_gpu = d[4:0];
        if (a == 8'h10) begin m_pi = m_pi | d[3:0]; m_pf = m_pf | d[7:4]; end
        if (a == 8'h14) begin m_pi = m_pi & ~d[3:0]; m_pf = m_pf & ~d[7:4]; end
        for (int c = 0; c < NC; c++) if (a == 8'(8'h40 + 4*c)) m_tcfg[c] = d[7:0];
        xfer(1'b1, a, d, dummy);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] r;
        xfer(1'b0, a, 32'h0, r);
        chk(tag, r, exp);
    endtask

    function automatic logic [31:0] e_pend(input int c);
        logic [31:0] v = '0;
        logic [1:0] dst = m_gpu[4] ? m_gpu[3:2] : m_gpu[1:0];
        for (int t = 0; t < 4; t++)
            v[t] = timer_req[c*4+t] & (m_tcfg[c][t] | m_tcfg[c][t+4]);
        v[7:4] = mbox_req[c*4 +: 4];
        v[8]   = gpu_req && (int'(dst) == c);
        v[9]   = pmu_req[c] & (m_pi[c] | m_pf[c]);
        v[10]  = (c == 0) && axi_req;
        v[11]  = (c == 0) && ltmr_req;
        return v;
    endfunction

    function automatic logic [3:0] e_irq();
        logic [3:0] v;
        for (int c = 0; c < NC; c++)
            v[c] = (|(timer_req[c*4 +: 4] & m_tcfg[c][3:0])) || (|mbox_req[c*4 +: 4])
                || (gpu_req && !m_gpu[4] && int'(m_gpu[1:0]) == c)
                || (pmu_req[c] && m_pi[c]) || (c == 0 && (axi_req || ltmr_req));
        return v;
    endfunction

    function automatic logic [3:0] e_fiq();
        logic [3:0] v;
        for (int c = 0; c < NC; c++)
            v[c] = (|(timer_req[c*4 +: 4] & m_tcfg[c][7:4]))
                || (gpu_req && m_gpu[4] && int'(m_gpu[3:2]) == c)
                || (pmu_req[c] && m_pf[c]);
        return v;
    endfunction

    task automatic chk_out(input string tag);
        #1;
        chk({tag, " irq"}, {28'b0, irq}, {28'b0, e_irq()});
        chk({tag, " fiq"}, {28'b0, fiq}, {28'b0, e_fiq()});
    endtask

    task automatic chk_pend_all(input string tag);
        for (int c = 0; c < NC; c++) rd_chk(tag, 8'(8'h60 + 4*c), e_pend(c));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) m_tcfg[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_out("R1 reset");
        rd_chk("R1 ctrl", 8'h00, 0);
        rd_chk("R1 presc", 8'h08, 0);
        rd_chk("R1 gpu", 8'h0C, 0);
        rd_chk("R1 pmu set", 8'h10, 0);
        rd_chk("R1 pmu clr", 8'h14, 0);
        for (int c = 0; c < NC; c++) rd_chk("R1 tcfg", 8'(8'h40 + 4*c), 0);
        chk_pend_all("R1 pend");
        gpu_req = 1'b1;
        #1 chk("R1 gpu to core0 irq", {28'b0, irq}, 32'h1);
        chk("R1 gpu no fiq", {28'b0, fiq}, 32'h0);
        gpu_req = 1'b0;

        // R2 / R3: storage words and unmapped offsets
        wr(8'h00, 32'hA5C3_0F96);
        wr(8'h08, 32'h8000_0000);
        rd_chk("R3 ctrl", 8'h00, 32'hA5C3_0F96);
        rd_chk("R3 presc", 8'h08, 32'h8000_0000);
        wr(8'h00, 32'h5A3C_F069);
        rd_chk("R3 ctrl2", 8'h00, 32'h5A3C_F069);
        rd_chk("R2 unmapped 04", 8'h04, 0);
        rd_chk("R2 unmapped 18", 8'h18, 0);
        rd_chk("R2 unmapped 42", 8'h42, 0);
        rd_chk("R2 unmapped 70", 8'h70, 0);

        // R4 / R5 / R9: full timer config sweep per core
        for (int c = 0; c < NC; c++) begin
            for (int v = 0; v < 256; v++) begin
                wr(8'(8'h40 + 4*c), {24'hC3A5E7, 8'(v)});
                rd_chk("R4 tcfg readback", 8'(8'h40 + 4*c), 32'(v));
                for (int p = 0; p < 16; p++) begin
                    timer_req = 16'(p) << (4*c);
                    chk_out("R4 R9 timer");
                end
                timer_req = 16'hF << (4*c);
                rd_chk("R5 timer pend", 8'(8'h60 + 4*c), e_pend(c));
            end
            wr(8'(8'h40 + 4*c), 32'h0);
            timer_req = 16'hFFFF;
            chk_out("R4 zero disables");
            rd_chk("R4 zero pend", 8'(8'h60 + 4*c), e_pend(c));
            timer_req = '0;
        end

        // R6: GPU route sweep
        gpu_req = 1'b1;
        for (int r = 0; r < 32; r++) begin
            wr(8'h0C, {27'h5ABCDEF, 5'(r)});
            rd_chk("R6 gpu readback", 8'h0C, 32'(r));
            chk_out("R6 gpu route");
            chk("R6 one core", 32'($countones(irq | fiq)), 32'd1);
            chk_pend_all("R6 gpu pend");
        end
        gpu_req = 1'b0;
        chk_out("R6 gpu idle");
        wr(8'h0C, 32'h0);

        // R7: PMU set/clear
        wr(8'h10, 32'h0F);
        rd_chk("R7 set read", 8'h10, 32'h0F);
        rd_chk("R7 clr read", 8'h14, 32'h0F);
        for (int p = 0; p < 16; p++) begin pmu_req = 4'(p); chk_out("R7 pmu irq"); end
        wr(8'h10, 32'hF0);
        rd_chk("R7 set both", 8'h14, 32'hFF);
        wr(8'h14, 32'h05);
        rd_chk("R7 clr some", 8'h10, 32'hFA);
        for (int p = 0; p < 16; p++) begin pmu_req = 4'(p); chk_out("R7 pmu mix"); end
        pmu_req = 4'hF;
        chk_pend_all("R7 pmu pend");
        wr(8'h14, 32'hFF);
        rd_chk("R7 all clear", 8'h10, 32'h0);
        chk_out("R7 cleared");
        chk_pend_all("R7 cleared pend");
        pmu_req = '0;

        // R8: mailboxes, AXI, local timer
        for (int c = 0; c < NC; c++) begin
            for (int m = 0; m < 16; m++) begin
                mbox_req = 16'(m) << (4*c);
                chk_out("R8 mbox");
            end
            mbox_req = 16'hA << (4*c);
            rd_chk("R8 mbox pend", 8'(8'h60 + 4*c), e_pend(c));
        end
        mbox_req = '0;
        axi_req = 1'b1;
        chk_out("R8 axi");
        chk_pend_all("R8 axi pend");
        axi_req = 1'b0; ltmr_req = 1'b1;
        chk_out("R8 ltmr");
        chk_pend_all("R8 ltmr pend");
        ltmr_req = 1'b0;

        // R10: pending words ignore writes
        wr(8'h40, 32'h21);
        wr(8'h4C, 32'h84);
        wr(8'h10, 32'h24);
        wr(8'h0C, 32'h1B);
        timer_req = 16'hF00F; pmu_req = 4'hF; gpu_req = 1'b1;
        for (int c = 0; c < NC; c++) begin
            logic [31:0] dummy;
            xfer(1'b1, 8'(8'h60 + 4*c), 32'hFFFF_FFFF, dummy);
        end
        rd_chk("R10 tcfg0 kept", 8'h40, 32'h21);
        rd_chk("R10 tcfg3 kept", 8'h4C, 32'h84);
        rd_chk("R10 pmu kept", 8'h10, 32'h24);
        rd_chk("R10 gpu kept", 8'h0C, 32'h1B);
        chk_out("R10 outputs");
        chk_pend_all("R10 pend");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule